// File: doc/BRIEF.md
# Dual-Channel PCM Serial Receiver

This block takes 8-bit PCM samples from a four-wire serial bus (a bit clock, a frame sync and two data lines) and hands each finished sample to the rest of the chip as a parallel byte with a one-cycle valid strobe. A fast system clock oversamples every bus input, so the bus clock never clocks any flop in the block.

The block has two modes. In parallel mode each data line carries its own channel, and both bytes are received side by side. In serial mode the first data line is unused and the second line carries channel 1 followed by channel 2 in the same frame.

A rising edge on the frame sync marks the start of a frame. The receiver also watches the bit clock. If the bit clock stays at one level for longer than a programmed number of system clocks, the receiver raises a power-save flag and drops any frame that is partly received.

Top module: `pcm_rx_dual`

## Requirements
- R1: While reset is asserted and straight after it is released, both data outputs read 0x00, both valid strobes are low and the power-save flag is low.
- R2: A data bit is taken on each falling edge of the bit clock. The first falling edge after a rising edge of the frame sync carries the most significant bit of the byte, so the first bit received lands in bit 7 of the output.
- R3: In parallel mode, data line 1 feeds channel 1 and data line 2 feeds channel 2. On the eighth bit of a frame, both valid strobes pulse in the same cycle.
- R4: Each valid strobe is high for exactly one system clock for each sample. The matching data output keeps its value until the next strobe on that channel.
- R5: In serial mode, data line 1 is ignored. Bits 1 to 8 of the frame on data line 2 form channel 1 and bits 9 to 16 form channel 2. The channel-1 strobe pulses on bit 8, and the channel-2 strobe pulses on bit 16 as a separate pulse.
- R6: Bits that arrive after a frame's last sample and before the next rising edge of the sync produce no strobe and change no output.
- R7: A rising edge of the sync in the middle of a byte restarts the bit count without any output. The next eight bits form the sample.
- R8: The power-save flag rises once the bit clock has shown no edge for idleLimit+1 system clocks. This holds whether the clock is stuck high or stuck low.
- R9: The power-save flag clears on the next detected edge of the bit clock, rising or falling.
- R10: Entering power save abandons any partly received frame. No strobe occurs until a new rising edge of the sync starts a full frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that oversamples the bus |
| rstN | input | 1 | Active-low synchronous reset |
| serialMode | input | 1 | 1: both channels on data line 2; 0: one channel per line |
| idleLimit | input | IDLE_W | Number of idle system clocks before power save |
| bitClk | input | 1 | Bus bit clock, asynchronous to clk |
| frameSync | input | 1 | Frame sync; its rising edge starts a frame |
| dataLine1 | input | 1 | Serial data line 1 |
| dataLine2 | input | 1 | Serial data line 2 |
| ch1Data | output | SAMPLE_BITS | Last received channel-1 sample |
| ch1Valid | output | 1 | One-cycle strobe for a new channel-1 sample |
| ch2Data | output | SAMPLE_BITS | Last received channel-2 sample |
| ch2Valid | output | 1 | One-cycle strobe for a new channel-2 sample |
| powerSave | output | 1 | High while the bit clock is seen as stopped |

## Verification
The assertions rely on two conditions at the inputs:
- Each level of the bit clock lasts at least two system clocks, so two falling edges are never seen in back-to-back cycles.
- The frame sync and the data lines change only while the bit clock is high, so a sync rising edge never lands in the same cycle as a falling edge.

The stimulus meets both conditions. It holds each bit-clock phase for eight system clocks and drives data and sync only at the rising transition of the bit clock. The stop-clock scenarios hold the clock for well over idleLimit cycles, stuck low and then stuck high, before the clock moves again.

// File: rtl/pcm_rx_pkg.sv
package pcm_rx_pkg;
  // Strobes from the control to the datapath, one set per system clock
  typedef struct packed {
    logic shift;        // take one bit from each synchronized data line
    logic loadCh1;      // move the assembled channel-1 byte to the output
    logic loadCh2;      // move the assembled channel-2 byte to the output
    logic ch1FromLine2; // channel 1 is assembled from data line 2
  } rxStrobes_t;
endpackage

// File: rtl/pcm_rx_insync.sv
module pcm_rx_insync #(
  parameter int WIDTH  = 4,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [WIDTH-1:0] asyncIn,
  output logic [WIDTH-1:0] syncOut
);
  logic [WIDTH-1:0] stage [STAGES];

  // Chain of flops; each input bit passes through every stage
  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    always_ff @(posedge clk) begin
      if (!rstN) stage[s] <= '0;
      else if (s == 0) stage[s] <= asyncIn;
      else stage[s] <= stage[(s == 0) ? 0 : s - 1];
    end
  end

  assign syncOut = stage[STAGES-1];
endmodule

// File: rtl/pcm_rx_ctrl.sv
module pcm_rx_ctrl
  import pcm_rx_pkg::*;
#(
  parameter int SAMPLE_BITS = 8,
  parameter int IDLE_W      = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              serialMode,
  input  logic [IDLE_W-1:0] idleLimit,
  input  logic              bclkS,
  input  logic              syncS,
  output rxStrobes_t        strb,
  output logic              powerSave
);
  localparam int FRAME_BITS = 2 * SAMPLE_BITS;
  localparam int CNT_W      = $clog2(FRAME_BITS);

  logic              bclkPrev, syncPrev;
  logic [CNT_W-1:0]  bitCnt, curCnt;
  logic              frameActive, curActive;
  logic [IDLE_W-1:0] idleCnt;
  logic bclkFall, bclkEdge, syncRise, enterPs, doShift;
  logic lastOfFirst, lastOfSecond, frameDone;

  always_comb begin
    bclkFall     = bclkPrev & ~bclkS;
    bclkEdge     = bclkPrev ^ bclkS;
    syncRise     = syncS & ~syncPrev;
    enterPs      = !bclkEdge && !powerSave && (idleCnt == idleLimit);
    curCnt       = syncRise ? '0 : bitCnt;
    curActive    = syncRise | frameActive;
    doShift      = bclkFall && curActive;
    lastOfFirst  = (curCnt == CNT_W'(SAMPLE_BITS - 1));
    lastOfSecond = (curCnt == CNT_W'(FRAME_BITS - 1));
    frameDone    = serialMode ? lastOfSecond : lastOfFirst;
    strb.shift        = doShift;
    strb.loadCh1      = doShift && lastOfFirst;
    strb.loadCh2      = doShift && (serialMode ? lastOfSecond : lastOfFirst);
    strb.ch1FromLine2 = serialMode;
  end

  // Edge history of the synchronized bus clock and sync
  always_ff @(posedge clk) begin
    if (!rstN) begin
      bclkPrev <= 1'b0;
      syncPrev <= 1'b0;
    end else begin
      bclkPrev <= bclkS;
      syncPrev <= syncS;
    end
  end

  // Frame bit counter
  always_ff @(posedge clk) begin
    if (!rstN) begin
      bitCnt      <= '0;
      frameActive <= 1'b0;
    end else if (enterPs) begin
      bitCnt      <= '0;
      frameActive <= 1'b0;
    end else if (doShift) begin
      if (frameDone) begin
        bitCnt      <= '0;
        frameActive <= 1'b0;
      end else begin
        bitCnt      <= curCnt + 1'b1;
        frameActive <= 1'b1;
      end
    end else if (syncRise) begin
      bitCnt      <= '0;
      frameActive <= 1'b1;
    end
  end

  // Stopped-clock watchdog
  always_ff @(posedge clk) begin
    if (!rstN) begin
      idleCnt   <= '0;
      powerSave <= 1'b0;
    end else if (bclkEdge) begin
      idleCnt   <= '0;
      powerSave <= 1'b0;
    end else if (enterPs) begin
      powerSave <= 1'b1;
    end else if (!powerSave) begin
      idleCnt <= idleCnt + 1'b1;
    end
  end

  // R9
  ps_clear_chk: assert property (@(posedge clk) disable iff (!rstN)
    (powerSave && bclkEdge) |=> !powerSave);

  // R8
  ps_entry_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(powerSave) |-> $past(!bclkEdge));

  // R10
  ps_no_load_chk: assert property (@(posedge clk) disable iff (!rstN)
    powerSave |-> !(strb.loadCh1 || strb.loadCh2));

  // R5
  serial_order_chk: assert property (@(posedge clk) disable iff (!rstN)
    (serialMode && strb.loadCh2) |-> !strb.loadCh1);
endmodule

// File: rtl/pcm_rx_dp.sv
module pcm_rx_dp
  import pcm_rx_pkg::*;
#(
  parameter int SAMPLE_BITS = 8
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  rxStrobes_t             strb,
  input  logic                   line1S,
  input  logic                   line2S,
  output logic [SAMPLE_BITS-1:0] ch1Data,
  output logic                   ch1Valid,
  output logic [SAMPLE_BITS-1:0] ch2Data,
  output logic                   ch2Valid
);
  logic [SAMPLE_BITS-1:0] shiftA, shiftB, nextA, nextB;

  // The bit being taken now is included in the value that gets loaded
  assign nextA = {shiftA[SAMPLE_BITS-2:0], line1S};
  assign nextB = {shiftB[SAMPLE_BITS-2:0], line2S};

  always_ff @(posedge clk) begin
    if (!rstN) begin
      shiftA   <= '0;
      shiftB   <= '0;
      ch1Data  <= '0;
      ch2Data  <= '0;
      ch1Valid <= 1'b0;
      ch2Valid <= 1'b0;
    end else begin
      ch1Valid <= strb.loadCh1;
      ch2Valid <= strb.loadCh2;
      if (strb.shift) begin
        shiftA <= nextA;
        shiftB <= nextB;
      end
      if (strb.loadCh1) ch1Data <= strb.ch1FromLine2 ? nextB : nextA;
      if (strb.loadCh2) ch2Data <= nextB;
    end
  end

  // R4
  ch1_pulse_chk: assert property (@(posedge clk) disable iff (!rstN)
    ch1Valid |=> !ch1Valid);

  // R4
  ch2_pulse_chk: assert property (@(posedge clk) disable iff (!rstN)
    ch2Valid |=> !ch2Valid);

  // R6
  ch1_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    !strb.loadCh1 |=> $stable(ch1Data));
endmodule

// File: rtl/pcm_rx_dual.sv
module pcm_rx_dual
  import pcm_rx_pkg::*;
#(
  parameter int SAMPLE_BITS = 8,
  parameter int IDLE_W      = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  logic                   serialMode,
  input  logic [IDLE_W-1:0]      idleLimit,
  input  logic                   bitClk,
  input  logic                   frameSync,
  input  logic                   dataLine1,
  input  logic                   dataLine2,
  output logic [SAMPLE_BITS-1:0] ch1Data,
  output logic                   ch1Valid,
  output logic [SAMPLE_BITS-1:0] ch2Data,
  output logic                   ch2Valid,
  output logic                   powerSave
);
  logic [3:0] busS;
  rxStrobes_t strb;

  pcm_rx_insync #(.WIDTH(4), .STAGES(SYNC_STAGES)) i_insync (
    .clk(clk), .rstN(rstN),
    .asyncIn({dataLine2, dataLine1, frameSync, bitClk}),
    .syncOut(busS)
  );

  pcm_rx_ctrl #(.SAMPLE_BITS(SAMPLE_BITS), .IDLE_W(IDLE_W)) i_ctrl (
    .clk(clk), .rstN(rstN), .serialMode(serialMode), .idleLimit(idleLimit),
    .bclkS(busS[0]), .syncS(busS[1]), .strb(strb), .powerSave(powerSave)
  );

  pcm_rx_dp #(.SAMPLE_BITS(SAMPLE_BITS)) i_dp (
    .clk(clk), .rstN(rstN), .strb(strb),
    .line1S(busS[2]), .line2S(busS[3]),
    .ch1Data(ch1Data), .ch1Valid(ch1Valid),
    .ch2Data(ch2Data), .ch2Valid(ch2Valid)
  );
endmodule

// File: tb/test_pcm_rx_dual.sv
module test_pcm_rx_dual;
  localparam int HALF = 8;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic serialMode = 1'b0;
  logic [15:0] idleLimit = 16'd40;
  logic bitClk = 1'b0, frameSync = 1'b0, dataLine1 = 1'b0, dataLine2 = 1'b0;
  logic [7:0] ch1Data, ch2Data;
  logic ch1Valid, ch2Valid, powerSave;

  int checks = 0, fails = 0;
  int c1Cnt = 0, c2Cnt = 0, bothCnt = 0;
  logic [7:0] last1 = '0, last2 = '0;
  bit done = 0;

  always #2.5 clk = ~clk;

  pcm_rx_dual i_pcm_rx_dual (
    .clk(clk), .rstN(rstN), .serialMode(serialMode), .idleLimit(idleLimit),
    .bitClk(bitClk), .frameSync(frameSync), .dataLine1(dataLine1),
    .dataLine2(dataLine2), .ch1Data(ch1Data), .ch1Valid(ch1Valid),
    .ch2Data(ch2Data), .ch2Valid(ch2Valid), .powerSave(powerSave)
  );

  always @(negedge clk) if (rstN) begin
    if (ch1Valid) begin c1Cnt++; last1 = ch1Data; end
    if (ch2Valid) begin c2Cnt++; last2 = ch2Data; end
    if (ch1Valid && ch2Valid) bothCnt++;
  end

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic sendBit(input logic b1, input logic b2, input logic s);
    @(negedge clk);
    bitClk = 1'b1; dataLine1 = b1; dataLine2 = b2; frameSync = s;
    repeat (HALF) @(negedge clk);
    bitClk = 1'b0;
    repeat (HALF) @(negedge clk);
  endtask

  task automatic sendByte(input logic [7:0] a, input logic [7:0] b, input bit withSync);
    for (int i = 7; i >= 0; i--) sendBit(a[i], b[i], withSync && i >= 4);
  endtask

  task automatic testReset();
    check("R1 ch1Data", ch1Data, 0);
    check("R1 ch2Data", ch2Data, 0);
    check("R1 valids", {ch1Valid, ch2Valid}, 0);
    check("R1 powerSave", powerSave, 0);
  endtask

  task automatic testParallel(input logic [7:0] a, input logic [7:0] b);
    int p1 = c1Cnt, p2 = c2Cnt, pb = bothCnt;
    serialMode = 1'b0;
    sendByte(a, b, 1);
    check("R2 ch1 MSB-first", last1, a);
    check("R3 ch2 from line 2", last2, b);
    check("R3 simultaneous strobes", bothCnt - pb, 1);
    check("R4 one ch1 strobe", c1Cnt - p1, 1);
    check("R4 one ch2 strobe", c2Cnt - p2, 1);
  endtask

  task automatic testTrailing();
    int p1 = c1Cnt, p2 = c2Cnt;
    sendByte(8'h0F, 8'hF0, 0);
    check("R6 no strobe on trailing bits", (c1Cnt - p1) + (c2Cnt - p2), 0);
    check("R6 ch1Data held", ch1Data, last1);
  endtask

  task automatic testSerial(input logic [7:0] a, input logic [7:0] b);
    int p1 = c1Cnt, p2 = c2Cnt, pb = bothCnt;
    serialMode = 1'b1;
    sendByte(8'hC3, a, 1);
    check("R5 ch1 strobe after bit 8", c1Cnt - p1, 1);
    check("R5 no ch2 strobe yet", c2Cnt - p2, 0);
    check("R5 ch1 from line 2", last1, a);
    sendByte(8'h3C, b, 0);
    check("R5 ch2 strobe after bit 16", c2Cnt - p2, 1);
    check("R5 ch2 value", last2, b);
    check("R5 strobes separate", bothCnt - pb, 0);
    serialMode = 1'b0;
  endtask

  task automatic testMidSync();
    int p1 = c1Cnt;
    serialMode = 1'b0;
    for (int i = 0; i < 5; i++) sendBit(1'b1, 1'b1, i < 2);
    sendByte(8'h5A, 8'hA5, 1);
    check("R7 single sample after restart", c1Cnt - p1, 1);
    check("R7 restart value", last1, 8'h5A);
  endtask

  task automatic testPowerSave();
    int p1;
    repeat (60) @(negedge clk);
    check("R8 stuck-low power save", powerSave, 1);
    bitClk = 1'b1;
    repeat (5) @(negedge clk);
    check("R9 clears on edge", powerSave, 0);
    repeat (60) @(negedge clk);
    check("R8 stuck-high power save", powerSave, 1);
    bitClk = 1'b0;
    repeat (5) @(negedge clk);
    check("R9 clears on falling edge", powerSave, 0);
    p1 = c1Cnt;
    for (int i = 0; i < 4; i++) sendBit(1'b0, 1'b0, i < 2);
    repeat (60) @(negedge clk);
    check("R8 power save mid-frame", powerSave, 1);
    for (int i = 0; i < 8; i++) sendBit(1'b1, 1'b1, 1'b0);
    check("R10 abandoned frame gives no sample", c1Cnt - p1, 0);
    sendByte(8'h96, 8'h69, 1);
    check("R10 new frame after power save", last1, 8'h96);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (4) @(negedge clk);
    testReset();
    rstN = 1'b1;
    @(negedge clk);
    testReset();
    testParallel(8'hA5, 8'h3C);
    testParallel(8'hFF, 8'h00);
    testTrailing();
    testSerial(8'h81, 8'h7E);
    testMidSync();
    testPowerSave();
    testParallel(8'h01, 8'h80);
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule